// File: doc/BRIEF.md
# Dual-Tree Interrupt Status Router

This block collects the error events of one command-fetch DMA channel and presents them as interrupts. Events arrive as single-cycle pulses. They are latched into two 32-bit status words, and software clears them by writing ones to a status address. Each status bit has its own enable for each of two interrupt trees. Software changes an enable only through an atomic write-one-to-set address or an atomic write-one-to-clear address for that tree and word. No read-modify-write is needed, so two agents can own different bits without racing each other.

Each tree output is the registered OR of status AND enable across both words. Word 1 also carries a context-not-valid error, which is raised by a small detector on engine and channel-start conditions. It is not raised while the engine reports itself halted. While it is pending, the block holds a stall output that keeps the loaded channel from being swapped out until software clears the bit.

Top module: `irq_tree_router`

## Requirements
- R1: Word 0 (status address 0) latches an event pulse only on bit positions 13-19, 21, 23-27, 30 and 31 (mask 0xCFAFE000). Pulses on any other position are ignored, and those bits read 0.
- R2: Word 1 (status address 1) latches the five copy-engine event inputs evt1_i[4:0] into bits 4:0. Bit 5 is context-not-valid. Bits 31:6 always read 0.
- R3: A write to a status address clears exactly the bits written as one. Bits written as zero keep their value, so writing all ones clears the word.
- R4: When an event and a software clear hit the same status bit in the same cycle, the event wins and the bit ends set.
- R5: The enable-set address for tree t and word w is 2 + 4t + 2w. A one written there enables that implemented bit, and a zero has no effect. Both the set and clear addresses read back the current mask.
- R6: The enable-clear address for tree t and word w is 3 + 4t + 2w. A one written there disables that bit, and a zero has no effect.
- R7: irq_tree_o[t] equals the OR over both words of (status AND tree t's enable), registered, so it changes one cycle after the status or enable change.
- R8: Context-not-valid is set when an engine method is presented (eng_mthd_i) while the target engine's context-valid flag is low.
- R9: Context-not-valid is set on a channel start or resume when every preemptible engine's context-valid is low and at least one of reload, should-send-event or needs-event is high. Otherwise a start sets nothing.
- R10: While halted_i is high, context-not-valid is not set, whatever the detector inputs are.
- R11: stall_o is high exactly while context-not-valid (word 1 bit 5) is pending. It falls on the same edge as the software clear of that bit.
- R12: After reset, all status words, all enable masks, both tree outputs and stall_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Read data (combinational) |
| evt0_i | input | 32 | Event pulses for word 0 |
| evt1_i | input | 5 | Copy-engine event pulses for word 1 |
| halted_i | input | 1 | Engine halted, blocks context-not-valid |
| eng_mthd_i | input | 1 | Engine method presented to target |
| tgt_ctx_valid_i | input | 1 | Target engine context valid |
| chan_start_i | input | 1 | Channel start or resume pulse |
| preempt_ctx_valid_i | input | NUM_PREEMPT | Context-valid flags of preemptible engines |
| reload_i | input | 1 | Context reload requested |
| should_send_i | input | 1 | Group event should be sent |
| needs_evt_i | input | 1 | Group event is needed |
| irq_tree_o | output | NUM_TREES | Per-tree interrupt outputs |
| stall_o | output | 1 | Context swap stall |

## Verification
A wrong status or enable flop appears at rd_data as soon as the register is read. It also appears on a tree output one cycle after the corrupted bit meets an enabled partner. A lost or spurious context-not-valid shows on stall_o in the cycle after the triggering pulse. Misplaced implemented-bit masks show as bits that read back set, or fail to set, after an all-ones pulse or an all-ones enable write.

// File: rtl/irq_tree_pkg.sv
// Package: shared widths and implemented-bit masks for the interrupt router.
// Assumes exactly two status words of DW bits each.
package irq_tree_pkg;
    localparam int DW        = 32;
    localparam int NUM_WORDS = 2;
    localparam int CE_SRCS   = 5;
    localparam int CTX_BIT   = 5;
    localparam logic [DW-1:0] W0_IMPL = 32'hCFAF_E000;
    localparam logic [DW-1:0] W1_IMPL = 32'h0000_003F;

    // Returns the implemented-bit mask of status word w.
    function automatic logic [DW-1:0] impl_mask(input int w);
        return (w == 0) ? W0_IMPL : W1_IMPL;
    endfunction
endpackage

// File: rtl/irq_status_word.sv
// Module: one status word. Event pulses set bits, software write-one clears.
// Assumes evt_i is a single-cycle pulse vector; only IMPL bits exist.
module irq_status_word
    import irq_tree_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          clr_we,
    input  logic [DW-1:0] clr_data,
    output logic [DW-1:0] status_o
);
    logic [DW-1:0] status_q;
    logic [DW-1:0] clr_vec;

    // Clear vector active only on a write to this word.
    always_comb clr_vec = clr_we ? clr_data : '0;

    // Latch events after applying the clear so that events win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_vec) | evt_i) & IMPL;
    end

    assign status_o = status_q;

    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & IMPL)) |=> ((status_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~evt_i)) == '0));
    a_r1_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/irq_enable_bank.sv
// Module: one enable mask, changed only by write-one-to-set / write-one-to-clear.
// Assumes set_we and clr_we come from distinct addresses (never both high).
module irq_enable_bank
    import irq_tree_pkg::*;
#(
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_o
);
    logic [DW-1:0] mask_q;
    logic [DW-1:0] set_vec, clr_vec;

    // Qualify write data by the strobe for each direction.
    always_comb begin
        set_vec = set_we ? wdata : '0;
        clr_vec = clr_we ? wdata : '0;
    end

    // Update the mask bits named by ones; zeros leave bits alone.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= ((mask_q | set_vec) & ~clr_vec) & IMPL;
    end

    assign mask_o = mask_q;

    a_r5_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
    a_r6_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_q & $past(wdata)) == '0));
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irq_ctx_detect.sv
// Module: context-not-valid event detector with halt gating (combinational).
// Assumes inputs are sampled in the same cycle as the status word latch.
module irq_ctx_detect #(
    parameter int NUM_PREEMPT = 2
) (
    input  logic                   eng_mthd_i,
    input  logic                   tgt_ctx_valid_i,
    input  logic                   chan_start_i,
    input  logic [NUM_PREEMPT-1:0] preempt_ctx_valid_i,
    input  logic                   reload_i,
    input  logic                   should_send_i,
    input  logic                   needs_evt_i,
    input  logic                   halted_i,
    output logic                   ctx_evt_o
);
    logic mthd_fault, start_fault;

    // Raise on a method to an invalid target, or a start with no valid context.
    always_comb begin
        mthd_fault  = eng_mthd_i && !tgt_ctx_valid_i;
        start_fault = chan_start_i && !(|preempt_ctx_valid_i)
                      && (reload_i || should_send_i || needs_evt_i);
        ctx_evt_o   = (mthd_fault || start_fault) && !halted_i;
    end
endmodule

// File: rtl/irq_tree_reduce.sv
// Module: per-tree AND-OR reduction of status against enables, registered.
// Assumes status and enables are already limited to implemented bits.
module irq_tree_reduce
    import irq_tree_pkg::*;
#(
    parameter int NUM_TREES = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_WORDS-1:0][DW-1:0]                  stat_i,
    input  logic [NUM_TREES-1:0][NUM_WORDS-1:0][DW-1:0]   en_i,
    output logic [NUM_TREES-1:0]                          irq_o
);
    logic [NUM_TREES-1:0] hit;
    logic [NUM_TREES-1:0] irq_q;

    for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
        // OR of enabled pending bits across every word for tree t.
        always_comb begin
            hit[t] = 1'b0;
            for (int w = 0; w < NUM_WORDS; w++)
                hit[t] = hit[t] | (|(stat_i[w] & en_i[t][w]));
        end
    end

    // Register the tree outputs to cut the reduction from the output pins.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= hit;
    end

    assign irq_o = irq_q;

    a_r7_tree_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((irq_q & $past(hit)) == $past(hit)));
    a_r7_tree_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> (irq_q == '0));
endmodule

// File: rtl/irq_tree_router.sv
// Module: top of the dual-tree interrupt router. Decodes the register port,
// holds two status words, NUM_TREES x 2 enable masks and drives tree outputs
// and the context-swap stall. Assumes one write per cycle; read is combinational.
module irq_tree_router
    import irq_tree_pkg::*;
#(
    parameter int NUM_TREES   = 2,
    parameter int NUM_PREEMPT = 2,
    parameter int AW          = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [31:0]            rd_data,
    input  logic [31:0]            evt0_i,
    input  logic [4:0]             evt1_i,
    input  logic                   halted_i,
    input  logic                   eng_mthd_i,
    input  logic                   tgt_ctx_valid_i,
    input  logic                   chan_start_i,
    input  logic [NUM_PREEMPT-1:0] preempt_ctx_valid_i,
    input  logic                   reload_i,
    input  logic                   should_send_i,
    input  logic                   needs_evt_i,
    output logic [NUM_TREES-1:0]   irq_tree_o,
    output logic                   stall_o
);
    localparam int EN_BASE = NUM_WORDS;

    logic                                        ctx_evt;
    logic [NUM_WORDS-1:0][DW-1:0]                evt_vec;
    logic [NUM_WORDS-1:0][DW-1:0]                stat;
    logic [NUM_WORDS-1:0]                        stat_clr_we;
    logic [NUM_TREES-1:0][NUM_WORDS-1:0][DW-1:0] en;
    logic [NUM_TREES-1:0][NUM_WORDS-1:0]         en_set_we, en_clr_we;

    irq_ctx_detect #(.NUM_PREEMPT(NUM_PREEMPT)) u_ctx (
        .eng_mthd_i(eng_mthd_i), .tgt_ctx_valid_i(tgt_ctx_valid_i),
        .chan_start_i(chan_start_i), .preempt_ctx_valid_i(preempt_ctx_valid_i),
        .reload_i(reload_i), .should_send_i(should_send_i),
        .needs_evt_i(needs_evt_i), .halted_i(halted_i), .ctx_evt_o(ctx_evt)
    );

    // Assemble the per-word event vectors.
    always_comb begin
        evt_vec[0] = evt0_i;
        evt_vec[1] = '0;
        evt_vec[1][CE_SRCS-1:0] = evt1_i;
        evt_vec[1][CTX_BIT]     = ctx_evt;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Status write decode for word w.
        always_comb stat_clr_we[w] = wr_en && (wr_addr == AW'(w));

        irq_status_word #(.IMPL(impl_mask(w))) u_stat (
            .clk(clk), .rst_n(rst_n), .evt_i(evt_vec[w]),
            .clr_we(stat_clr_we[w]), .clr_data(wr_data), .status_o(stat[w])
        );

        for (genvar t = 0; t < NUM_TREES; t++) begin : g_en
            localparam int SA = EN_BASE + (t*NUM_WORDS + w)*2;
            // Set/clear decode for tree t, word w.
            always_comb begin
                en_set_we[t][w] = wr_en && (wr_addr == AW'(SA));
                en_clr_we[t][w] = wr_en && (wr_addr == AW'(SA+1));
            end

            irq_enable_bank #(.IMPL(impl_mask(w))) u_en (
                .clk(clk), .rst_n(rst_n), .set_we(en_set_we[t][w]),
                .clr_we(en_clr_we[t][w]), .wdata(wr_data), .mask_o(en[t][w])
            );
        end
    end

    // Read mux: status words first, then each mask at both of its addresses.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr == AW'(w)) rd_data = stat[w];
            for (int t = 0; t < NUM_TREES; t++) begin
                if (rd_addr == AW'(EN_BASE + (t*NUM_WORDS + w)*2) ||
                    rd_addr == AW'(EN_BASE + (t*NUM_WORDS + w)*2 + 1))
                    rd_data = en[t][w];
            end
        end
    end

    irq_tree_reduce #(.NUM_TREES(NUM_TREES)) u_red (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .en_i(en), .irq_o(irq_tree_o)
    );

    assign stall_o = stat[1][CTX_BIT];

    a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_i && !stall_o) |=> !stall_o);
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !(stat_clr_we[1] && wr_data[CTX_BIT])) |=> stall_o);
    a_r8_method_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_mthd_i && !tgt_ctx_valid_i && !halted_i) |=> stall_o);
    a_r2_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat[1][DW-1:CTX_BIT+1] == '0));
endmodule

// File: tb/sim_irq_tree_router.sv
module sim_irq_tree_router;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IMPL0 = 32'hCFAF_E000;
    localparam logic [63:0] VECS [0:7] = '{
        {32'hFFFF_FFFF, 32'hCFAF_E000},
        {32'h0000_1FFF, 32'h0000_0000},
        {32'h0000_2000, 32'h0000_2000},
        {32'h0010_0000, 32'h0000_0000},
        {32'h8000_0000, 32'h8000_0000},
        {32'h2000_0000, 32'h0000_0000},
        {32'h0400_0000, 32'h0400_0000},
        {32'h12A5_4321, 32'h02A5_4000}
    };

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [3:0] wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data, evt0 = 0;
    logic [4:0] evt1 = 0;
    logic halted = 0, mthd = 0, tgtv = 1, start = 0, rl = 0, ss = 0, ne = 0;
    logic [1:0] prev = 2'b11;
    logic [1:0] irq;
    logic stall;
    int tests = 0, failed = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_tree_router u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt0_i(evt0), .evt1_i(evt1), .halted_i(halted), .eng_mthd_i(mthd),
        .tgt_ctx_valid_i(tgtv), .chan_start_i(start),
        .preempt_ctx_valid_i(prev), .reload_i(rl), .should_send_i(ss),
        .needs_evt_i(ne), .irq_tree_o(irq), .stall_o(stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = 0;
    endtask

    task automatic pulse0(input logic [31:0] v);
        @(negedge clk); evt0 = v;
        @(negedge clk); evt0 = 0;
    endtask

    task automatic ctxp(input logic m, tv, st, input logic [1:0] pv, input logic r, s, n);
        @(negedge clk); mthd = m; tgtv = tv; start = st; prev = pv; rl = r; ss = s; ne = n;
        @(negedge clk); mthd = 0; tgtv = 1; start = 0; prev = 2'b11; rl = 0; ss = 0; ne = 0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d); chk("R12 reset read", d, 0);
        end
        chk("R12 reset irq", {30'd0, irq}, 0);
        chk("R12 reset stall", {31'd0, stall}, 0);

        // R1 vector table walk
        for (int i = 0; i < 8; i++) begin
            pulse0(VECS[i][63:32]);
            rd(4'd0, d); chk("R1 latch", d, VECS[i][31:0]);
            wr(4'd0, 32'hFFFF_FFFF);
            rd(4'd0, d); chk("R3 clear all", d, 0);
        end

        // R2 copy-engine sources
        @(negedge clk); evt1 = 5'h1F;
        @(negedge clk); evt1 = 0;
        rd(4'd1, d); chk("R2 word1 latch", d, 32'h1F);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d); chk("R2 word1 clear", d, 0);

        // R3 partial clear and zero write
        pulse0(32'hFFFF_FFFF);
        wr(4'd0, 32'h0000_6000);
        rd(4'd0, d); chk("R3 partial clear", d, 32'hCFAF_8000);
        wr(4'd0, 32'h0);
        rd(4'd0, d); chk("R3 zero write", d, 32'hCFAF_8000);

        // R4 event beats same-cycle clear
        @(negedge clk); evt0 = 32'h0000_2000; wr_en = 1; wr_addr = 0; wr_data = 32'hFFFF_FFFF;
        @(negedge clk); evt0 = 0; wr_en = 0; wr_data = 0;
        rd(4'd0, d); chk("R4 event wins", d, 32'h0000_2000);
        wr(4'd0, 32'hFFFF_FFFF);

        // R5 enable set, readback at both addresses, zero write
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R5 set readback", d, IMPL0);
        rd(4'd3, d); chk("R5 clr-addr readback", d, IMPL0);
        wr(4'd2, 32'h0);
        rd(4'd2, d); chk("R5 zero set no effect", d, IMPL0);
        wr(4'd8, 32'h0000_0021);
        rd(4'd9, d); chk("R5 tree1 word1 set", d, 32'h21);

        // R6 enable clear
        wr(4'd3, 32'h0000_E000);
        rd(4'd2, d); chk("R6 clear bits", d, 32'hCFAF_0000);
        wr(4'd3, 32'h0);
        rd(4'd2, d); chk("R6 zero clear no effect", d, 32'hCFAF_0000);

        // R7 tree reduction and one-cycle lag
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0000_0004);
        @(negedge clk); evt1 = 5'h04;
        @(negedge clk); evt1 = 0;
        chk("R7 lag before", {30'd0, irq}, 0);
        @(negedge clk);
        chk("R7 tree1 asserted", {30'd0, irq}, 32'h2);
        wr(4'd9, 32'h0000_0004);
        chk("R7 hold after enable clear", {30'd0, irq}, 32'h2);
        @(negedge clk);
        chk("R7 tree1 dropped", {30'd0, irq}, 0);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'h8000_0000);
        pulse0(32'h8000_0000);
        @(negedge clk);
        chk("R7 tree0 from word0", {30'd0, irq}, 32'h1);
        wr(4'd0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 tree0 dropped on status clear", {30'd0, irq}, 0);

        // R8 method to invalid target
        ctxp(1, 1, 0, 2'b00, 0, 0, 0);
        chk("R8 valid target no fault", {31'd0, stall}, 0);
        ctxp(1, 0, 0, 2'b11, 0, 0, 0);
        rd(4'd1, d); chk("R8 ctx bit set", d, 32'h20);

        // R11 stall holds until cleared
        repeat (3) @(negedge clk);
        chk("R11 stall held", {31'd0, stall}, 1);
        wr(4'd1, 32'h0000_001F);
        chk("R11 other clear keeps stall", {31'd0, stall}, 1);
        wr(4'd1, 32'h0000_0020);
        chk("R11 stall released", {31'd0, stall}, 0);

        // R9 start/resume conditions
        ctxp(0, 1, 1, 2'b01, 1, 0, 0);
        chk("R9 one valid context no fault", {31'd0, stall}, 0);
        ctxp(0, 1, 1, 2'b00, 0, 0, 0);
        chk("R9 no flag no fault", {31'd0, stall}, 0);
        ctxp(0, 1, 1, 2'b00, 1, 0, 0);
        chk("R9 reload fault", {31'd0, stall}, 1);
        wr(4'd1, 32'h20);
        ctxp(0, 1, 1, 2'b00, 0, 0, 1);
        chk("R9 needs-event fault", {31'd0, stall}, 1);
        wr(4'd1, 32'h20);
        ctxp(0, 1, 1, 2'b00, 0, 1, 0);
        chk("R9 should-send fault", {31'd0, stall}, 1);
        wr(4'd1, 32'h20);

        // R10 halted suppresses
        @(negedge clk); halted = 1;
        ctxp(1, 0, 1, 2'b00, 1, 1, 1);
        rd(4'd1, d); chk("R10 halted no set", d, 0);
        @(negedge clk); halted = 0;
        ctxp(1, 0, 0, 2'b11, 0, 0, 0);
        chk("R10 unhalted sets", {31'd0, stall}, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; failed++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule